// File: doc/BRIEF.md
# Ethernet Transmit Frame Encapsulator

This block takes frame payload from an external show-ahead transmit FIFO and sends it as an untagged Ethernet frame. The FIFO word is 16 bits wide and carries two byte enables and an end-of-frame flag. Output is an 8-bit byte stream with a valid strobe, in the style of a gigabit media-independent interface. The block puts the preamble and start delimiter in front of the payload. It fills short payloads up to the minimum size, appends a CRC-32 frame check sequence when that is enabled, and keeps the line quiet for at least the inter-packet gap between frames.

The FIFO shows its head word whenever `fifo_avail` is high, and `fifo_rd` pops that word at the clock edge. Payload has to flow without gaps until end-of-frame. If a word is needed and none is there, the frame is cut short and recorded as an underrun. Three static inputs set the behaviour: an enable, a switch that turns off FCS generation, and a switch that turns off padding. A software layer should change them only while no frame is in progress. The enable is sampled only between frames. At the end of each frame a statistics vector comes out with a one-cycle strobe, and a done pulse is given for frames sent without error.

Top module: `eth_tx_encap`

## Requirements
- R1: Every frame starts on `txd` with seven octets of 0x55 and then one octet of 0xD5, with `tx_en` high, before any payload octet.
- R2: Lane bits [15:8] are sent before lane bits [7:0]. `fifo_be[1]` qualifies the upper lane and `fifo_be[0]` the lower lane. Only the final word may enable a single lane: value 2'b10 sends only the upper lane and 2'b01 sends only the lower lane.
- R3: Each octet on `txd` is its lane byte bit-reversed: lane bit 7 (or 15) drives `txd[0]` and lane bit 0 (or 8) drives `txd[7]`.
- R4: With padding and FCS both enabled, a payload shorter than 60 octets is followed by octets of 0xAA until 60 octets have gone out. The FCS follows.
- R5: With FCS enabled, four FCS octets follow the payload and pad. They are the CRC-32 (polynomial 0x04C11DB7, reflected, initial all ones, result inverted) over every octet after the delimiter, sent least significant byte first. With `cfg_fcs_off` high, no FCS is sent.
- R6: With `cfg_fcs_off` high, the payload is sent exactly as given and never padded. Statistics bit 16 is set when that frame is shorter than 64 octets and clear otherwise.
- R7: Between the last octet of one frame and the first octet of the next, `tx_en` stays low for at least 12 cycles.
- R8: `fifo_rd` is high only while `fifo_avail` is high. If a word is needed within a frame and `fifo_avail` is low, the frame ends after the octets already taken. No FCS is sent, statistics bit 17 is set and `tx_done` stays low.
- R9: A frame starts only while `cfg_enable` and `fifo_avail` are both high. Dropping `cfg_enable` during a frame lets that frame finish, and no further frame starts.
- R10: `stat_valid` pulses for one cycle, in the same cycle as the final octet of the frame on `txd`. `stat_vec[15:0]` holds the count of octets after the delimiter, including pad and FCS. Bit 18 means pad was added and bit 19 means an FCS was appended. `tx_done` pulses in that same cycle only if there was no underrun.
- R11: While and right after reset, `tx_en`, `tx_done`, `stat_valid` and `fifo_rd` are low.
- R12: With padding disabled and FCS enabled, a short payload is sent unpadded and is directly followed by its FCS.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Allows new frames to start |
| cfg_fcs_off | input | 1 | Suppresses FCS generation |
| cfg_pad_off | input | 1 | Suppresses padding of short payloads |
| fifo_avail | input | 1 | FIFO head word is valid |
| fifo_data | input | 16 | FIFO head word, first octet in [15:8] |
| fifo_be | input | 2 | Lane enables for the head word |
| fifo_eof | input | 1 | Head word is the last of its frame |
| fifo_rd | output | 1 | Pops the head word at this clock edge |
| txd | output | 8 | Transmit octet |
| tx_en | output | 1 | Transmit octet valid |
| tx_done | output | 1 | Frame completed without error |
| stat_valid | output | 1 | Qualifies stat_vec |
| stat_vec | output | 20 | Frame statistics |

## Verification
Two events always share a cycle: the final octet of a frame and its statistics strobe (with `tx_done`). That final octet can be the last FCS byte, the last payload byte when FCS is off, or the byte taken just before an underrun. The bench provokes all three endings. Its monitor requires `tx_en` to be high whenever `stat_valid` is, and compares the vector and the done flag against the scoreboard's entry. A second overlap, between the enable being dropped and a frame already in flight, is provoked by clearing the enable while octets are streaming. The bench then checks that the frame still completes and that the next queued frame stays in the FIFO.

// File: rtl/eth_tx_pkg.sv
// Shared definitions for the transmit encapsulator: FSM states,
// statistics field positions, fixed octet values, CRC helpers.
package eth_tx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE,
        S_DATA,
        S_PAD,
        S_FCS,
        S_GAP
    } tx_state_e;

    localparam int LEN_W    = 16;
    localparam int STAT_W   = LEN_W + 4;
    localparam int ST_SHORT = LEN_W;
    localparam int ST_UNDER = LEN_W + 1;
    localparam int ST_PAD   = LEN_W + 2;
    localparam int ST_FCS   = LEN_W + 3;

    localparam logic [7:0] PRE_OCT = 8'h55;
    localparam logic [7:0] SFD_OCT = 8'hD5;
    localparam logic [7:0] PAD_OCT = 8'hAA;

    // Mirror a 32-bit value so an MSB-first polynomial suits an LSB-first shifter.
    function automatic logic [31:0] reflect32(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = v[31-i];
        return r;
    endfunction

endpackage

// File: rtl/eth_tx_lane.sv
// Holds the FIFO word currently being serialised and presents both lanes
// already bit-reversed into line order (lane MSB becomes octet bit 0).
// Assumes the controller loads a new word only after the old one is used.
module eth_tx_lane (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [15:0] word_in,
    input  logic [1:0]  be_in,
    input  logic        eof_in,
    output logic [7:0]  hi_oct,
    output logic [7:0]  lo_oct,
    output logic [1:0]  be_q,
    output logic        eof_q
);

    logic [15:0] word_q;

    // Capture the popped word together with its qualifiers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            be_q   <= '0;
            eof_q  <= 1'b0;
        end else if (load) begin
            word_q <= word_in;
            be_q   <= be_in;
            eof_q  <= eof_in;
        end
    end

    // Per-lane bit reversal onto the line octet.
    for (genvar b = 0; b < 8; b++) begin : g_rev
        assign hi_oct[b] = word_q[15-b];
        assign lo_oct[b] = word_q[7-b];
    end

endmodule

// File: rtl/eth_tx_crc.sv
// Byte-wide reflected CRC-32 accumulator over line octets.
// Assumes clear and update are never requested together.
module eth_tx_crc
    import eth_tx_pkg::*;
#(
    parameter logic [31:0] POLY = 32'h04C11DB7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        update,
    input  logic [7:0]  octet,
    output logic [31:0] crc
);

    localparam logic [31:0] RPOLY = reflect32(POLY);

    logic [31:0] crc_q;
    logic [31:0] crc_nxt;

    // Fold one octet in, least significant bit first.
    always_comb begin
        crc_nxt = crc_q ^ {24'd0, octet};
        for (int i = 0; i < 8; i++)
            crc_nxt = crc_nxt[0] ? ((crc_nxt >> 1) ^ RPOLY) : (crc_nxt >> 1);
    end

    // Running remainder register.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) crc_q <= '1;
        else if (update)     crc_q <= crc_nxt;
    end

    assign crc = crc_q;

endmodule

// File: rtl/eth_tx_encap.sv
// Transmit frame encapsulator: preamble, payload unpacking, padding,
// FCS, inter-packet gap and end-of-frame statistics.
// Assumes a show-ahead FIFO (head valid while fifo_avail, popped by fifo_rd)
// and configuration inputs that change only between frames.
module eth_tx_encap
    import eth_tx_pkg::*;
#(
    parameter int          PRE_LEN   = 8,
    parameter int          MIN_LEN   = 60,
    parameter int          SHORT_LEN = 64,
    parameter int          IPG_LEN   = 12,
    parameter logic [31:0] CRC_POLY  = 32'h04C11DB7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_fcs_off,
    input  logic              cfg_pad_off,
    input  logic              fifo_avail,
    input  logic [15:0]       fifo_data,
    input  logic [1:0]        fifo_be,
    input  logic              fifo_eof,
    output logic              fifo_rd,
    output logic [7:0]        txd,
    output logic              tx_en,
    output logic              tx_done,
    output logic              stat_valid,
    output logic [STAT_W-1:0] stat_vec
);

    localparam int CNT_W = $clog2((IPG_LEN > PRE_LEN ? IPG_LEN : PRE_LEN) + 1);
    localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(PRE_LEN - 1);
    localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(IPG_LEN - 1);
    localparam logic [CNT_W-1:0] FCS_LAST = CNT_W'(3);
    localparam logic [LEN_W-1:0] MIN_L    = LEN_W'(MIN_LEN);
    localparam logic [LEN_W-1:0] SHORT_L  = LEN_W'(SHORT_LEN);
    localparam logic [LEN_W-1:0] PADDED_L = LEN_W'(MIN_LEN + 4);

    tx_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              phase_q, phase_d;
    logic [LEN_W-1:0]  len_q, len_d;
    logic              under_q, under_d;
    logic              padded_q, padded_d;

    logic              load, emit, crc_clr, crc_upd, fin, fcs_done;
    logic [7:0]        octet;
    logic [7:0]        hi_oct, lo_oct;
    logic [1:0]        be_q;
    logic              eof_q;
    logic [31:0]       crc;
    logic [31:0]       fcs_val;
    logic [7:0]        fcs_oct;
    logic [STAT_W-1:0] stat_d;

    logic [7:0]        txd_q;
    logic              tx_en_q, done_q, stat_valid_q;
    logic [STAT_W-1:0] stat_q;

    eth_tx_lane u_lane (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .word_in (fifo_data),
        .be_in   (fifo_be),
        .eof_in  (fifo_eof),
        .hi_oct  (hi_oct),
        .lo_oct  (lo_oct),
        .be_q    (be_q),
        .eof_q   (eof_q)
    );

    eth_tx_crc #(.POLY(CRC_POLY)) u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (crc_clr),
        .update (crc_upd),
        .octet  (octet),
        .crc    (crc)
    );

    // Pick the FCS octet for this position, low byte first.
    assign fcs_val = ~crc;
    always_comb begin
        case (cnt_q[1:0])
            2'd0:    fcs_oct = fcs_val[7:0];
            2'd1:    fcs_oct = fcs_val[15:8];
            2'd2:    fcs_oct = fcs_val[23:16];
            default: fcs_oct = fcs_val[31:24];
        endcase
    end

    // Frame sequencing: next state, octet choice, FIFO pops and end of frame.
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        phase_d  = phase_q;
        len_d    = len_q;
        under_d  = under_q;
        padded_d = padded_q;
        fifo_rd  = 1'b0;
        load     = 1'b0;
        emit     = 1'b0;
        octet    = 8'h00;
        crc_clr  = 1'b0;
        crc_upd  = 1'b0;
        fin      = 1'b0;
        fcs_done = 1'b0;
        case (state_q)
            S_IDLE: begin
                if (cfg_enable && fifo_avail) begin
                    state_d = S_PRE;
                    cnt_d   = '0;
                end
            end
            S_PRE: begin
                emit     = 1'b1;
                crc_clr  = 1'b1;
                len_d    = '0;
                under_d  = 1'b0;
                padded_d = 1'b0;
                cnt_d    = cnt_q + CNT_W'(1);
                if (cnt_q == PRE_LAST) begin
                    octet = SFD_OCT;
                    if (fifo_avail) begin
                        fifo_rd = 1'b1;
                        load    = 1'b1;
                        phase_d = ~fifo_be[1];
                        state_d = S_DATA;
                    end else begin
                        under_d = 1'b1;
                        fin     = 1'b1;
                        state_d = S_GAP;
                        cnt_d   = '0;
                    end
                end else begin
                    octet = PRE_OCT;
                end
            end
            S_DATA: begin
                emit    = 1'b1;
                crc_upd = 1'b1;
                len_d   = len_q + LEN_W'(1);
                octet   = phase_q ? lo_oct : hi_oct;
                if (phase_q || !be_q[0]) begin
                    if (eof_q) begin
                        if (!cfg_fcs_off && !cfg_pad_off && len_d < MIN_L) begin
                            state_d  = S_PAD;
                            padded_d = 1'b1;
                        end else if (!cfg_fcs_off) begin
                            state_d = S_FCS;
                            cnt_d   = '0;
                        end else begin
                            fin     = 1'b1;
                            state_d = S_GAP;
                            cnt_d   = '0;
                        end
                    end else if (fifo_avail) begin
                        fifo_rd = 1'b1;
                        load    = 1'b1;
                        phase_d = ~fifo_be[1];
                    end else begin
                        under_d = 1'b1;
                        fin     = 1'b1;
                        state_d = S_GAP;
                        cnt_d   = '0;
                    end
                end else begin
                    phase_d = 1'b1;
                end
            end
            S_PAD: begin
                emit    = 1'b1;
                crc_upd = 1'b1;
                octet   = PAD_OCT;
                len_d   = len_q + LEN_W'(1);
                if (len_d == MIN_L) begin
                    state_d = S_FCS;
                    cnt_d   = '0;
                end
            end
            S_FCS: begin
                emit  = 1'b1;
                octet = fcs_oct;
                len_d = len_q + LEN_W'(1);
                cnt_d = cnt_q + CNT_W'(1);
                if (cnt_q == FCS_LAST) begin
                    fin      = 1'b1;
                    fcs_done = 1'b1;
                    state_d  = S_GAP;
                    cnt_d    = '0;
                end
            end
            S_GAP: begin
                cnt_d = cnt_q + CNT_W'(1);
                if (cnt_q == GAP_LAST) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Assemble the statistics word for the frame that is finishing.
    assign stat_d = {fcs_done, padded_d, under_d,
                     cfg_fcs_off && (len_d < SHORT_L), len_d};

    // State and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= S_IDLE;
            cnt_q        <= '0;
            phase_q      <= 1'b0;
            len_q        <= '0;
            under_q      <= 1'b0;
            padded_q     <= 1'b0;
            txd_q        <= '0;
            tx_en_q      <= 1'b0;
            done_q       <= 1'b0;
            stat_valid_q <= 1'b0;
            stat_q       <= '0;
        end else begin
            state_q      <= state_d;
            cnt_q        <= cnt_d;
            phase_q      <= phase_d;
            len_q        <= len_d;
            under_q      <= under_d;
            padded_q     <= padded_d;
            txd_q        <= octet;
            tx_en_q      <= emit;
            done_q       <= fin && !under_d;
            stat_valid_q <= fin;
            if (fin) stat_q <= stat_d;
        end
    end

    assign txd        = txd_q;
    assign tx_en      = tx_en_q;
    assign tx_done    = done_q;
    assign stat_valid = stat_valid_q;
    assign stat_vec   = stat_q;

    // R8: the FIFO is never popped while empty.
    p_pop_needs_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> fifo_avail);

    // R10: done only alongside a strobe that reports no underrun.
    p_done_qualified_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> (stat_valid && !stat_vec[ST_UNDER]));

    // R10: the statistics strobe lasts a single cycle.
    p_strobe_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |=> !stat_valid);

    // R7: the line stays quiet while the gap is counted.
    p_gap_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_GAP) |=> !tx_en);

    // R9: a frame begins only after the enable was seen in idle.
    p_start_enabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> $past(cfg_enable, 2));

    // R6: a short flag never comes with an appended FCS.
    p_short_no_fcs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && stat_vec[ST_SHORT]) |-> !stat_vec[ST_FCS]);

    // R4: padded frames always reach exactly minimum plus FCS.
    p_pad_reaches_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && stat_vec[ST_PAD]) |-> (stat_vec[LEN_W-1:0] == PADDED_L));

endmodule

// File: tb/eth_tx_encap_test.sv
// Scoreboard bench: send_frame pushes FIFO words plus expected octets and
// statistics; a monitor pops and compares as the design emits them.
module eth_tx_encap_test;
    import eth_tx_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk; // 50 MHz

    logic              rst_n, cfg_enable, cfg_fcs_off, cfg_pad_off;
    logic              fifo_avail, fifo_eof, fifo_rd;
    logic [15:0]       fifo_data;
    logic [1:0]        fifo_be;
    logic [7:0]        txd;
    logic              tx_en, tx_done, stat_valid;
    logic [STAT_W-1:0] stat_vec;

    eth_tx_encap uut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
        .cfg_fcs_off(cfg_fcs_off), .cfg_pad_off(cfg_pad_off),
        .fifo_avail(fifo_avail), .fifo_data(fifo_data), .fifo_be(fifo_be),
        .fifo_eof(fifo_eof), .fifo_rd(fifo_rd), .txd(txd), .tx_en(tx_en),
        .tx_done(tx_done), .stat_valid(stat_valid), .stat_vec(stat_vec)
    );

    int checks = 0;
    int errors = 0;

    logic [18:0] fq[$];        // {eof, be, data}
    logic [7:0]  exp_oct[$];
    int          exp_tag[$];
    logic [20:0] exp_stat[$];  // {done, stat_vec}
    int          last_octets;

    function automatic logic [7:0] flip8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] x;
        x = c ^ {24'd0, b};
        for (int i = 0; i < 8; i++) x = x[0] ? ((x >> 1) ^ 32'hEDB88320) : (x >> 1);
        return x;
    endfunction

    function automatic logic [7:0] pbyte(input int seed, input int i);
        return 8'((seed * 13 + i * 29 + (i >> 3)) & 255);
    endfunction

    task automatic refresh();
        fifo_avail = (fq.size() != 0);
        if (fifo_avail) {fifo_eof, fifo_be, fifo_data} = fq[0];
        else            {fifo_eof, fifo_be, fifo_data} = '0;
    endtask

    task automatic push_exp(input logic [7:0] o, input int tag);
        exp_oct.push_back(o);
        exp_tag.push_back(tag);
        last_octets++;
    endtask

    // Driver: FIFO words plus expected line octets and statistics for one frame.
    task automatic send_frame(input int n, input int seed, input bit low_last, input bit starve);
        logic [31:0] c;
        logic [7:0]  a, b;
        int          len;
        bit          padded;
        bit          short_f;
        @(posedge clk); #3;
        last_octets = 0;
        for (int i = 0; i < 7; i++) push_exp(PRE_OCT, 1); // R1 preamble
        push_exp(SFD_OCT, 1);                             // R1 delimiter
        c = '1;
        for (int i = 0; i < n; i += 2) begin
            logic [15:0] w;
            logic [1:0]  be;
            bit          last;
            a = pbyte(seed, i);
            b = pbyte(seed, i + 1);
            last = (i + 2 >= n);
            if (n - i == 1 && low_last) begin w = {8'h00, flip8(a)}; be = 2'b01; end // R2 lower lane only
            else if (n - i == 1)        begin w = {flip8(a), 8'h00}; be = 2'b10; end // R2 upper lane only
            else                        begin w = {flip8(a), flip8(b)}; be = 2'b11; end
            fq.push_back({last && !starve, be, w});
            push_exp(a, 3); c = crc_step(c, a);       // R3 reversed lane octet
            if (n - i > 1) begin push_exp(b, 3); c = crc_step(c, b); end
        end
        len = n;
        padded = 1'b0;
        short_f = cfg_fcs_off && (n < 64);
        if (starve) begin
            exp_stat.push_back({1'b0, 1'b0, 1'b0, 1'b1, short_f, 16'(len)}); // R8
        end else begin
            if (!cfg_fcs_off && !cfg_pad_off) begin
                while (len < 60) begin
                    push_exp(PAD_OCT, 4); c = crc_step(c, PAD_OCT); len++; padded = 1'b1; // R4
                end
            end
            if (!cfg_fcs_off) begin
                c = ~c;
                for (int k = 0; k < 4; k++) push_exp(c[8*k +: 8], 5); // R5
                len += 4;
            end
            exp_stat.push_back({1'b1, !cfg_fcs_off, padded, 1'b0, short_f, 16'(len)}); // R10
        end
        refresh();
    endtask

    task automatic wait_idle();
        while (exp_oct.size() != 0 || exp_stat.size() != 0 || fq.size() != 0) @(negedge clk);
        repeat (20) @(negedge clk);
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // FIFO model: pop the head after an edge at which fifo_rd was high.
    initial begin
        forever begin
            logic r;
            @(negedge clk);
            r = fifo_rd;
            @(posedge clk);
            #1;
            if (r && fq.size() > 0) begin
                void'(fq.pop_front());
                refresh();
            end
        end
    end

    // Monitor: compare octets, gap length and statistics against the scoreboard.
    initial begin
        bit seen = 1'b0;
        bit prev_en = 1'b0;
        int idle_run = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (tx_en) begin
                    if (!prev_en && seen) begin
                        checks++;
                        if (idle_run < 12) begin
                            errors++;
                            $display("FAIL R7 gap: actual %0d idle cycles, expected >= 12", idle_run);
                        end
                    end
                    seen = 1'b1;
                    idle_run = 0;
                    checks++;
                    if (exp_oct.size() == 0) begin
                        errors++;
                        $display("FAIL R9 unexpected octet: actual %02h, expected none", txd);
                    end else begin
                        logic [7:0] e;
                        int t;
                        e = exp_oct.pop_front();
                        t = exp_tag.pop_front();
                        if (txd !== e) begin
                            errors++;
                            $display("FAIL R%0d octet: actual %02h, expected %02h", t, txd, e);
                        end
                    end
                end else begin
                    idle_run++;
                end
                if (stat_valid) begin
                    checks++;
                    if (!tx_en) begin
                        errors++;
                        $display("FAIL R10 strobe not with last octet: actual tx_en 0, expected 1");
                    end
                    if (exp_stat.size() == 0) begin
                        errors++;
                        $display("FAIL R10 stat: actual %h, expected none", stat_vec);
                    end else begin
                        logic [20:0] es;
                        es = exp_stat.pop_front();
                        if ({tx_done, stat_vec} !== es) begin
                            errors++;
                            $display("FAIL R10 stat/done: actual %h, expected %h", {tx_done, stat_vec}, es);
                        end
                    end
                end else if (tx_done) begin
                    checks++;
                    errors++;
                    $display("FAIL R10 done without strobe: actual 1, expected 0");
                end
                prev_en = tx_en;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung run, expected completion");
        report();
    end

    // Stimulus.
    initial begin
        int words2;
        int oct2;
        rst_n = 1'b0; cfg_enable = 1'b0; cfg_fcs_off = 1'b0; cfg_pad_off = 1'b0;
        refresh();
        repeat (5) @(negedge clk);
        checks++;
        if (tx_en || tx_done || stat_valid || fifo_rd) begin
            errors++;
            $display("FAIL R11 reset outputs: actual %b%b%b%b, expected 0000", tx_en, tx_done, stat_valid, fifo_rd);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (tx_en || tx_done || stat_valid || fifo_rd) begin
            errors++;
            $display("FAIL R11 after reset: actual %b%b%b%b, expected 0000", tx_en, tx_done, stat_valid, fifo_rd);
        end

        cfg_enable = 1'b1;
        send_frame(10, 1, 1'b0, 1'b0);          // R4 R5 short padded frame
        wait_idle();

        send_frame(61, 2, 1'b0, 1'b0);          // R2 odd length, upper lane last
        send_frame(100, 3, 1'b0, 1'b0);         // R7 back to back
        send_frame(9, 4, 1'b1, 1'b0);           // R2 lower lane last
        wait_idle();

        cfg_pad_off = 1'b1;
        send_frame(10, 5, 1'b0, 1'b0);          // R12 unpadded with FCS
        wait_idle();

        cfg_pad_off = 1'b0; cfg_fcs_off = 1'b1;
        send_frame(20, 6, 1'b0, 1'b0);          // R6 short flagged, not padded
        send_frame(70, 7, 1'b0, 1'b0);          // R6 long, no flag
        send_frame(63, 8, 1'b1, 1'b0);          // R6 boundary 63
        wait_idle();

        cfg_fcs_off = 1'b0;
        send_frame(6, 9, 1'b0, 1'b1);           // R8 underrun after six octets
        wait_idle();
        send_frame(12, 10, 1'b0, 1'b0);         // R8 recovery
        wait_idle();

        send_frame(40, 11, 1'b0, 1'b0);         // R9 disable mid-frame
        while (!tx_en) @(negedge clk);
        repeat (12) @(negedge clk);
        cfg_enable = 1'b0;
        send_frame(30, 12, 1'b0, 1'b0);
        oct2 = last_octets;
        words2 = 15;
        while (exp_stat.size() > 1) @(negedge clk);
        repeat (100) @(negedge clk);
        checks++;
        if (exp_oct.size() != oct2 || fq.size() != words2) begin
            errors++;
            $display("FAIL R9 held frame: actual %0d octets/%0d words left, expected %0d/%0d",
                     exp_oct.size(), fq.size(), oct2, words2);
        end
        cfg_enable = 1'b1;
        wait_idle();

        checks++;
        if (exp_oct.size() != 0 || exp_stat.size() != 0) begin
            errors++;
            $display("FAIL R10 leftover: actual %0d octets %0d stats, expected 0 0",
                     exp_oct.size(), exp_stat.size());
        end
        report();
    end

endmodule